// File: doc/BRIEF.md
# Programmable Chip-Select Wait-State Generator

This block serves one address region of a processor bus. On every bus cycle it checks whether the incoming address falls inside the region. The region is set by a base address and a 3-bit size code. On a hit it drives an active-low chip-select and then holds the access open for a programmable number of wait states. It ends the access either with an internal acknowledge or, when the wait code is set to its reserved value, when an external acknowledge arrives.

For write cycles the block drives separate upper and lower byte write strobes, shaped by the configured data-bus width. A flash option delays the write strobes by one clock behind chip-select. All programming arrives as static configuration inputs that are held steady while the bus is idle.

The controller walks five states. ST_IDLE waits for a qualified address strobe. ST_LEAD is the one-clock chip-select-only phase of a flash write. ST_COUNT runs the wait counter or waits for the external acknowledge. ST_TERM is the single terminating clock. ST_HOLD waits for the address strobe to be withdrawn. The transitions are:
- ST_IDLE goes to ST_LEAD on a flash write hit, and to ST_COUNT on any other hit.
- ST_LEAD goes to ST_COUNT.
- ST_COUNT goes to ST_TERM when the count is exhausted or the external acknowledge is seen.
- ST_LEAD and ST_COUNT go back to ST_IDLE when the address strobe is withdrawn (abort).
- ST_TERM goes to ST_HOLD.
- ST_HOLD goes to ST_IDLE once the address strobe is high.

Top module: `cs_wait_gen`

## Requirements
- R1: While reset is low, and on the first clock after it, `cs_n`, `uwe_n`, `lwe_n` and `ack_n` are all high, even when a matching address strobe is present.
- R2: An address hits when every address bit at position MIN_LOG2 + `cfg_size` and above equals the same bit of `cfg_base`. The lower bits are ignored. MIN_LOG2 is 17 by default, so code 0 gives 128 KB, each step doubles the size, and code 7 gives 16 MB. With SMALL_REGION=1, MIN_LOG2 is 15 and the sizes run from 32 KB to 4 MB.
- R3: With `cfg_en` low, `cs_n` never goes low.
- R4: For `cfg_wait` codes 0 to 6, the wait count W is 2*`cfg_wait` + `cfg_wait_lsb`. A non-flash access holds `cs_n` low for exactly W+2 clocks, and `ack_n` is low only in the last of those clocks.
- R5: With `cfg_wait` = 3'b111, the counter is ignored and `ack_n` stays high. `ext_ack_n` sampled low at a clock edge during the counting phase makes the next clock the last one with `cs_n` low.
- R6: One clock after the terminating clock, `cs_n`, `uwe_n`, `lwe_n` and `ack_n` are all high. They stay high until `bus_as_n` has been seen high and then low again.
- R7: On a write with `cfg_flash` = 1, `cs_n` goes low one clock before the write strobe and stays low W+3 clocks. The strobe stays low W+2 clocks. With `cfg_flash` = 0, or on a read, chip-select and strobe start on the same clock.
- R8: Write strobes are low only on writes (`bus_rnw` = 0) while chip-select is in its strobe phase. With `cfg_wide` = 1, `uwe_n` follows `bus_ub_n` and `lwe_n` follows `bus_lb_n`. With `cfg_wide` = 0, `lwe_n` is low on every write and `uwe_n` stays high.
- R9: `bus_wide` reports `cfg_wide` (1 = 16-bit, 0 = 8-bit).
- R10: If `bus_as_n` is high at a clock edge in ST_LEAD or ST_COUNT, the block returns to idle at that edge. This takes precedence over a count expiry or external acknowledge at the same edge, and no acknowledge is given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_en | input | 1 | Region enable |
| cfg_base | input | ADDR_W | Region base address |
| cfg_size | input | 3 | Region size code |
| cfg_wait | input | 3 | Upper wait-count bits; 3'b111 selects external acknowledge |
| cfg_wait_lsb | input | 1 | Wait-count least significant bit |
| cfg_wide | input | 1 | Data bus width, 1 = 16-bit |
| cfg_flash | input | 1 | Chip-select leads write strobes by one clock |
| bus_addr | input | ADDR_W | Bus address |
| bus_as_n | input | 1 | Address strobe, active low |
| bus_rnw | input | 1 | 1 = read, 0 = write |
| bus_ub_n | input | 1 | Upper byte select, active low |
| bus_lb_n | input | 1 | Lower byte select, active low |
| ext_ack_n | input | 1 | External acknowledge, active low |
| cs_n | output | 1 | Chip-select, active low |
| uwe_n | output | 1 | Upper byte write strobe, active low |
| lwe_n | output | 1 | Lower byte write strobe, active low |
| ack_n | output | 1 | Internal acknowledge, active low |
| bus_wide | output | 1 | Configured bus width |

## Verification
Cycle termination and address-strobe withdrawal can fall on the same clock edge. Termination comes either from the counter reaching zero or from the external acknowledge. The bench provokes the collision in two ways. It drops the address strobe in the first counting clock of a zero-wait access, which is the clock where the counter is already exhausted. In external mode it lowers the external acknowledge and raises the address strobe in the same clock. The bench judges the outcome from the pins. Chip-select must rise one clock later, with no extra terminating clock, and the internal acknowledge must never be seen low.

// File: rtl/cs_wait_pkg.sv
package cs_wait_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_LEAD  = 3'd1,
        ST_COUNT = 3'd2,
        ST_TERM  = 3'd3,
        ST_HOLD  = 3'd4
    } cs_state_t;

    localparam int unsigned WAIT_CODE_W = 3;
    localparam int unsigned WAIT_CNT_W  = WAIT_CODE_W + 1;
    localparam logic [WAIT_CODE_W-1:0] WAIT_EXT_CODE = '1;

    // Count is twice the code plus the separate low bit.
    function automatic logic [WAIT_CNT_W-1:0] wait_total(
        input logic [WAIT_CODE_W-1:0] code,
        input logic                   lsb
    );
        return {code, lsb};
    endfunction

endpackage

// File: rtl/cs_region_decode.sv
module cs_region_decode #(
    parameter int unsigned ADDR_W   = 24,
    parameter int unsigned MIN_LOG2 = 17
) (
    input  logic              en,
    input  logic [ADDR_W-1:0] base,
    input  logic [2:0]        size,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);

    logic [31:0]       boundary;
    logic [ADDR_W-1:0] keep;
    logic [ADDR_W-1:0] diff;

    assign boundary = 32'(MIN_LOG2) + {29'd0, size};
    assign diff     = addr ^ base;

    // Bits at or above the size boundary take part in the compare.
    for (genvar i = 0; i < ADDR_W; i++) begin : g_keep
        assign keep[i] = (32'(i) >= boundary);
    end

    assign hit = en && ((diff & keep) == '0);

endmodule

// File: rtl/cs_wait_timer.sv
module cs_wait_timer #(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             zero
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (dec && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/cs_strobe_drive.sv
module cs_strobe_drive (
    input  logic phase,
    input  logic rnw,
    input  logic wide,
    input  logic ub_n,
    input  logic lb_n,
    output logic uwe_n,
    output logic lwe_n
);

    logic wr_phase;
    logic upper_sel;
    logic lower_sel;

    assign wr_phase = phase && !rnw;

    always_comb begin
        if (wide) begin
            upper_sel = !ub_n;
            lower_sel = !lb_n;
        end else begin
            upper_sel = 1'b0;
            lower_sel = 1'b1;
        end
    end

    assign uwe_n = !(wr_phase && upper_sel);
    assign lwe_n = !(wr_phase && lower_sel);

endmodule

// File: rtl/cs_wait_gen.sv
module cs_wait_gen
    import cs_wait_pkg::*;
#(
    parameter int unsigned ADDR_W       = 24,
    parameter bit          SMALL_REGION = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_en,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [2:0]        cfg_size,
    input  logic [2:0]        cfg_wait,
    input  logic              cfg_wait_lsb,
    input  logic              cfg_wide,
    input  logic              cfg_flash,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_as_n,
    input  logic              bus_rnw,
    input  logic              bus_ub_n,
    input  logic              bus_lb_n,
    input  logic              ext_ack_n,
    output logic              cs_n,
    output logic              uwe_n,
    output logic              lwe_n,
    output logic              ack_n,
    output logic              bus_wide
);

    localparam int unsigned MIN_LOG2 = SMALL_REGION ? 15 : 17;

    cs_state_t              state_q;
    cs_state_t              state_d;
    logic                   region_hit;
    logic                   count_zero;
    logic                   timer_load;
    logic                   timer_dec;
    logic                   ext_mode;
    logic                   strobe_phase;
    logic [WAIT_CNT_W-1:0]  wait_val;

    assign ext_mode = (cfg_wait == WAIT_EXT_CODE);
    assign wait_val = wait_total(cfg_wait, cfg_wait_lsb);

    cs_region_decode #(
        .ADDR_W   (ADDR_W),
        .MIN_LOG2 (MIN_LOG2)
    ) u_decode (
        .en   (cfg_en),
        .base (cfg_base),
        .size (cfg_size),
        .addr (bus_addr),
        .hit  (region_hit)
    );

    // Reloaded in every state but ST_COUNT, so entry always starts full.
    assign timer_load = (state_q != ST_COUNT);
    assign timer_dec  = (state_q == ST_COUNT);

    cs_wait_timer #(
        .CNT_W (WAIT_CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (timer_load),
        .load_val (wait_val),
        .dec      (timer_dec),
        .zero     (count_zero)
    );

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (!bus_as_n && region_hit) begin
                    state_d = (cfg_flash && !bus_rnw) ? ST_LEAD : ST_COUNT;
                end
            end
            ST_LEAD: begin
                state_d = bus_as_n ? ST_IDLE : ST_COUNT;
            end
            ST_COUNT: begin
                if (bus_as_n) begin
                    state_d = ST_IDLE;
                end else if (ext_mode) begin
                    if (!ext_ack_n) begin
                        state_d = ST_TERM;
                    end
                end else if (count_zero) begin
                    state_d = ST_TERM;
                end
            end
            ST_TERM: begin
                state_d = ST_HOLD;
            end
            ST_HOLD: begin
                if (bus_as_n) begin
                    state_d = ST_IDLE;
                end
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // Output logic.
    always_comb begin
        cs_n         = 1'b1;
        ack_n        = 1'b1;
        strobe_phase = 1'b0;
        unique case (state_q)
            ST_LEAD: begin
                cs_n = 1'b0;
            end
            ST_COUNT: begin
                cs_n         = 1'b0;
                strobe_phase = 1'b1;
            end
            ST_TERM: begin
                cs_n         = 1'b0;
                strobe_phase = 1'b1;
                ack_n        = ext_mode;
            end
            ST_IDLE, ST_HOLD: begin
                cs_n = 1'b1;
            end
            default: begin
                cs_n = 1'b1;
            end
        endcase
    end

    cs_strobe_drive u_strobe (
        .phase (strobe_phase),
        .rnw   (bus_rnw),
        .wide  (cfg_wide),
        .ub_n  (bus_ub_n),
        .lb_n  (bus_lb_n),
        .uwe_n (uwe_n),
        .lwe_n (lwe_n)
    );

    assign bus_wide = cfg_wide;

endmodule

// File: rtl/cs_wait_gen_chk.sv
module cs_wait_gen_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_en,
    input logic [2:0] cfg_wait,
    input logic       cfg_wide,
    input logic       cfg_flash,
    input logic       bus_rnw,
    input logic       cs_n,
    input logic       uwe_n,
    input logic       lwe_n,
    input logic       ack_n
);

    assert_cs_needs_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> $past(cfg_en));

    assert_strobe_inside_cs_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!uwe_n || !lwe_n) |-> !cs_n);

    assert_read_no_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rnw |-> (uwe_n && lwe_n));

    assert_narrow_upper_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wide |-> uwe_n);

    assert_ack_then_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_n |=> (cs_n && ack_n && uwe_n && lwe_n));

    assert_ack_inside_cs_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_n |-> !cs_n);

    assert_ext_no_int_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wait == 3'b111) |-> ack_n);

    assert_flash_lead_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cs_n) && cfg_flash && !bus_rnw) |-> (uwe_n && lwe_n));

    assert_no_lead_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cs_n) && !cfg_flash && !bus_rnw && !cfg_wide) |-> !lwe_n);

endmodule

bind cs_wait_gen cs_wait_gen_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_en    (cfg_en),
    .cfg_wait  (cfg_wait),
    .cfg_wide  (cfg_wide),
    .cfg_flash (cfg_flash),
    .bus_rnw   (bus_rnw),
    .cs_n      (cs_n),
    .uwe_n     (uwe_n),
    .lwe_n     (lwe_n),
    .ack_n     (ack_n)
);

// File: tb/sim_cs_wait_gen.sv
module sim_cs_wait_gen;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_en = 1'b1;
    logic [AW-1:0] cfg_base = 24'h200000;
    logic [2:0]    cfg_size = 3'd3;
    logic [2:0]    cfg_wait = 3'd0;
    logic          cfg_wait_lsb = 1'b0;
    logic          cfg_wide = 1'b1;
    logic          cfg_flash = 1'b0;
    logic [AW-1:0] bus_addr = 24'h000000;
    logic          bus_as_n = 1'b1;
    logic          bus_rnw = 1'b1;
    logic          bus_ub_n = 1'b1;
    logic          bus_lb_n = 1'b1;
    logic          ext_ack_n = 1'b1;
    logic          cs_n, uwe_n, lwe_n, ack_n, bus_wide;

    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cs_wait_gen #(.ADDR_W(AW), .SMALL_REGION(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_base(cfg_base),
        .cfg_size(cfg_size), .cfg_wait(cfg_wait), .cfg_wait_lsb(cfg_wait_lsb),
        .cfg_wide(cfg_wide), .cfg_flash(cfg_flash), .bus_addr(bus_addr),
        .bus_as_n(bus_as_n), .bus_rnw(bus_rnw), .bus_ub_n(bus_ub_n),
        .bus_lb_n(bus_lb_n), .ext_ack_n(ext_ack_n), .cs_n(cs_n),
        .uwe_n(uwe_n), .lwe_n(lwe_n), .ack_n(ack_n), .bus_wide(bus_wide)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Results of one access, filled by run_access.
    int n_cs, n_ack, ack_pos, we_pos, n_uwe, n_lwe, n_late;

    // act_kind bit0: pull ext_ack_n low, bit1: raise bus_as_n, at cs-low clock act_at.
    task automatic run_access(input logic [AW-1:0] a, input logic rnw, input logic ub,
                              input logic lb, input int act_at, input int act_kind,
                              input int keep_as);
        bit started = 0;
        int idle_runs = 0;
        n_cs = 0; n_ack = 0; ack_pos = 0; we_pos = 0; n_uwe = 0; n_lwe = 0; n_late = 0;
        @(negedge clk);
        bus_addr = a; bus_rnw = rnw; bus_ub_n = ub; bus_lb_n = lb; bus_as_n = 1'b0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (!cs_n) begin
                started = 1;
                n_cs++;
                if (!ack_n) begin n_ack++; ack_pos = n_cs; end
                if ((!uwe_n || !lwe_n) && we_pos == 0) we_pos = n_cs;
                if (!uwe_n) n_uwe++;
                if (!lwe_n) n_lwe++;
                if (n_cs == act_at) begin
                    if (act_kind[0]) ext_ack_n = 1'b0;
                    if (act_kind[1]) bus_as_n = 1'b1;
                end
            end else begin
                if (started) begin
                    if (!uwe_n || !lwe_n || !ack_n) n_late++;
                    break;
                end
                idle_runs++;
                if (idle_runs >= 3) break;
            end
        end
        ext_ack_n = 1'b1;
        for (int j = 0; j < keep_as; j++) begin
            @(negedge clk);
            if (!cs_n || !uwe_n || !lwe_n || !ack_n) n_late++;
        end
        bus_as_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        bus_addr = 24'h200010; bus_as_n = 1'b0; bus_rnw = 1'b0; bus_lb_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1", "cs_n in reset", int'(cs_n), 1);
        chk("R1", "strobes in reset", int'(uwe_n & lwe_n), 1);
        chk("R1", "ack_n in reset", int'(ack_n), 1);
        bus_as_n = 1'b1; bus_rnw = 1'b1; bus_lb_n = 1'b1;
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "cs_n after reset", int'(cs_n), 1);
    endtask

    task automatic t_wait_counts();
        for (int c = 0; c < 7; c++) begin
            for (int l = 0; l < 2; l++) begin
                cfg_wait = 3'(c); cfg_wait_lsb = 1'(l);
                run_access(24'h200100, 1'b1, 1'b1, 1'b1, 0, 0, 0);
                chk("R4", $sformatf("cs clocks code=%0d lsb=%0d", c, l), n_cs, 2*c + l + 2);
                chk("R4", "ack at last clock", ack_pos * 100 + n_ack, (2*c + l + 2) * 100 + 1);
            end
        end
        cfg_wait = 3'd0; cfg_wait_lsb = 1'b0;
    endtask

    task automatic t_decode();
        cfg_base = 24'h240000; cfg_size = 3'd0;
        run_access(24'h25FFFF, 1'b1, 1'b1, 1'b1, 0, 0, 0);
        chk("R2", "128K top of region hits", int'(n_cs > 0), 1);
        run_access(24'h260000, 1'b1, 1'b1, 1'b1, 0, 0, 0);
        chk("R2", "128K just above misses", n_cs, 0);
        run_access(24'h23FFFF, 1'b1, 1'b1, 1'b1, 0, 0, 0);
        chk("R2", "128K just below misses", n_cs, 0);
        cfg_base = 24'h200000; cfg_size = 3'd3;
        run_access(24'h2ABCDE, 1'b1, 1'b1, 1'b1, 0, 0, 0);
        chk("R2", "1M inside hits", int'(n_cs > 0), 1);
        run_access(24'h300000, 1'b1, 1'b1, 1'b1, 0, 0, 0);
        chk("R2", "1M outside misses", n_cs, 0);
        cfg_size = 3'd7;
        run_access(24'hF12345, 1'b1, 1'b1, 1'b1, 0, 0, 0);
        chk("R2", "16M any address hits", int'(n_cs > 0), 1);
        cfg_size = 3'd3;
    endtask

    task automatic t_enable();
        cfg_en = 1'b0;
        run_access(24'h200200, 1'b0, 1'b0, 1'b0, 0, 0, 0);
        chk("R3", "disabled region no cs", n_cs, 0);
        chk("R3", "disabled region no strobe", n_lwe + n_uwe, 0);
        cfg_en = 1'b1;
    endtask

    task automatic t_ext();
        cfg_wait = 3'b111; cfg_wait_lsb = 1'b1;
        run_access(24'h200300, 1'b1, 1'b1, 1'b1, 5, 1, 0);
        chk("R5", "ext ack ends one clock later", n_cs, 6);
        chk("R5", "no internal ack in ext mode", n_ack, 0);
        run_access(24'h200300, 1'b1, 1'b1, 1'b1, 20, 1, 0);
        chk("R5", "counter ignored, long ext wait", n_cs, 21);
        cfg_wait = 3'd0; cfg_wait_lsb = 1'b0;
    endtask

    task automatic t_hold();
        cfg_wait = 3'd1;
        run_access(24'h200400, 1'b0, 1'b0, 1'b0, 0, 0, 4);
        chk("R6", "cs clocks before hold", n_cs, 4);
        chk("R6", "outputs high after term while AS low", n_late, 0);
        run_access(24'h200400, 1'b1, 1'b1, 1'b1, 0, 0, 0);
        chk("R6", "new cycle after AS toggle", n_cs, 4);
        cfg_wait = 3'd0;
    endtask

    task automatic t_flash();
        cfg_flash = 1'b1; cfg_wait = 3'd1; cfg_wide = 1'b0;
        run_access(24'h200500, 1'b0, 1'b1, 1'b1, 0, 0, 0);
        chk("R7", "flash write cs clocks", n_cs, 5);
        chk("R7", "flash strobe starts second clock", we_pos, 2);
        chk("R7", "flash strobe clocks", n_lwe, 4);
        run_access(24'h200500, 1'b1, 1'b1, 1'b1, 0, 0, 0);
        chk("R7", "flash read no lead", n_cs, 4);
        cfg_flash = 1'b0;
        run_access(24'h200500, 1'b0, 1'b1, 1'b1, 0, 0, 0);
        chk("R7", "non-flash strobe with cs", we_pos, 1);
        chk("R7", "non-flash cs clocks", n_cs, 4);
        cfg_wait = 3'd0; cfg_wide = 1'b1;
    endtask

    task automatic t_strobes();
        cfg_wide = 1'b1;
        chk("R9", "bus_wide 16-bit", int'(bus_wide), 1);
        run_access(24'h200600, 1'b0, 1'b0, 1'b1, 0, 0, 0);
        chk("R8", "wide upper only: uwe", n_uwe, 2);
        chk("R8", "wide upper only: lwe", n_lwe, 0);
        run_access(24'h200600, 1'b0, 1'b1, 1'b0, 0, 0, 0);
        chk("R8", "wide lower only", n_uwe * 10 + n_lwe, 2);
        run_access(24'h200600, 1'b1, 1'b0, 1'b0, 0, 0, 0);
        chk("R8", "read no strobes", n_uwe + n_lwe, 0);
        cfg_wide = 1'b0;
        #1;
        chk("R9", "bus_wide 8-bit", int'(bus_wide), 0);
        run_access(24'h200600, 1'b0, 1'b0, 1'b1, 0, 0, 0);
        chk("R8", "narrow write uses lower", n_uwe * 10 + n_lwe, 2);
        cfg_wide = 1'b1;
    endtask

    task automatic t_abort();
        cfg_wait = 3'd0;
        run_access(24'h200700, 1'b1, 1'b1, 1'b1, 1, 2, 0);
        chk("R10", "abort beats zero count", n_cs, 1);
        chk("R10", "no ack on abort", n_ack, 0);
        cfg_wait = 3'b111;
        run_access(24'h200700, 1'b1, 1'b1, 1'b1, 3, 3, 0);
        chk("R10", "abort beats ext ack", n_cs, 3);
        cfg_wait = 3'd6; cfg_wait_lsb = 1'b1;
        run_access(24'h200700, 1'b0, 1'b0, 1'b0, 4, 2, 0);
        chk("R10", "abort mid count", n_cs, 4);
        chk("R10", "no late outputs after abort", n_late, 0);
        cfg_wait = 3'd0; cfg_wait_lsb = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_wait_counts();
        t_decode();
        t_enable();
        t_ext();
        t_hold();
        t_flash();
        t_strobes();
        t_abort();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule